// File: doc/BRIEF.md
# Flash Command and Interrupt Status Controller

This block holds the command, configuration, controller-status and interrupt-status registers of a flash controller behind a 16-bit register bus. A host writes a command code; the block either settles it at once (resume, suspend, array-management codes, hot reset, unknown codes) or starts an external array engine with a one-cycle strobe. It then waits for that engine to answer with done, or with done and fail. On the answer it posts a completion bit for the command's class and, on failure, the matching error bits.

Software clears interrupt bits by writing a mask into the interrupt register. Clearing the master bit also clears every error flag. While the master bit is set, new commands are refused. The interrupt pin's polarity comes from a configuration bit. A ready pin takes its level from another configuration bit whenever configuration is written.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After the asynchronous cold reset, configuration reads 0x40C0, status reads 0x0000, interrupt reads 0x8080, command reads 0x0000, readyPin is 1 and intPin is 1.
- R2: A write to the interrupt register replaces its content with (old AND written value), on the same clock edge.
- R3: Whenever interrupt bit 15 (master) ends a cycle clear, status error bits 10 (command), 11 (erase), 12 (program) and 13 (load) are cleared. While bit 15 stays set, they are kept.
- R4: A command write made while interrupt bit 15 is set is ignored: the command register, interrupt, status and engStart are unchanged.
- R5: An accepted engine command (0x0000 or 0x0013 load; 0x0080, 0x001A or 0x001B program; 0x0094 or 0x0095 erase) raises engStart for exactly one cycle after the write edge, with engCmd equal to the code. Command writes are ignored until engDone returns, and engDone is ignored while no command is outstanding.
- R6: On engDone the interrupt register gains bit 15 plus the class done bit: load bit 7, program bit 6, erase bit 5. If engFail is also high, status gains bit 10 plus the class error bit: load 13, program 12, erase 11.
- R7: Code 0x0030 immediately sets interrupt bits 15 and 5. Code 0x00B0 changes neither interrupt nor status. Codes 0x0023, 0x0027, 0x002A, 0x002C, 0x0065 and 0x0071 set only interrupt bit 15.
- R8: Any other command code sets interrupt bit 15 and status bit 10.
- R9: Codes 0x00F0 and 0x00F3 perform a hot reset: configuration 0x40C0, status 0, interrupt 0x8010, command 0, readyPin 1.
- R10: intPin equals interrupt bit 15 XOR NOT configuration bit 6, at all times.
- R11: A configuration write stores all 16 bits and sets readyPin to bit 7 of the written value. Configuration reads back with bits 4..0 forced to 0.
- R12: When engDone and an interrupt-register write fall on the same edge, the result is (old AND written value) OR the completion bits, and the errors are kept because bit 15 ends set.
- R13: busSel selects a register for both read and write: 0 command, 1 configuration, 2 status (read-only, writes ignored), 3 interrupt. busRdData shows the selected register combinationally, and command codes are compared as full 16-bit values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low cold reset |
| busSel | input | 2 | Register select for read and write |
| busWr | input | 1 | Write strobe |
| busWrData | input | 16 | Write data |
| busRdData | output | 16 | Read data of the selected register |
| engStart | output | 1 | One-cycle launch strobe to the array engine |
| engCmd | output | 16 | Code of the launched command |
| engDone | input | 1 | Engine completion |
| engFail | input | 1 | Engine failure, qualified by engDone |
| intPin | output | 1 | Interrupt output, polarity from configuration |
| readyPin | output | 1 | Ready output from configuration |

## Verification
The interrupt register has two writers that can act on the same edge: software's AND-mask write and the engine completion that ORs in status bits. The bench provokes this by raising engDone, with and without engFail, in the very cycle it writes zero to the interrupt register. It then expects the completion bits to survive the mask, and the error flags to survive because the master bit ends set. The same scoreboard also confirms that each launch strobe matches the command queued by the driver.

// File: rtl/fcc_pkg.sv
package fcc_pkg;
  localparam int DATA_W = 16;
  localparam int SEL_W  = 2;

  localparam int B_MASTER = 15;
  localparam int B_RSTDN  = 4;
  localparam int B_ERADN  = 5;
  localparam int B_PRGDN  = 6;
  localparam int B_LDDN   = 7;
  localparam int B_ECMD   = 10;
  localparam int B_EERA   = 11;
  localparam int B_EPRG   = 12;
  localparam int B_ELD    = 13;

  localparam logic [DATA_W-1:0] ERR_MASK =
    (DATA_W'(1) << B_ECMD) | (DATA_W'(1) << B_EERA) |
    (DATA_W'(1) << B_EPRG) | (DATA_W'(1) << B_ELD);

  localparam logic [SEL_W-1:0] SEL_CMD  = 2'd0;
  localparam logic [SEL_W-1:0] SEL_CFG  = 2'd1;
  localparam logic [SEL_W-1:0] SEL_STAT = 2'd2;
  localparam logic [SEL_W-1:0] SEL_INT  = 2'd3;

  typedef enum logic [1:0] {CLS_NONE, CLS_LOAD, CLS_PROG, CLS_ERASE} opClass_e;

  typedef struct packed {
    logic              hotReset;
    logic              cmdLoad;
    logic [DATA_W-1:0] cmdCode;
    logic [DATA_W-1:0] intSet;
    logic [DATA_W-1:0] errSet;
  } ctlStrobe_t;

  function automatic logic [DATA_W-1:0] bitOf(input int pos);
    return DATA_W'(1) << pos;
  endfunction

  function automatic opClass_e classOf(input logic [DATA_W-1:0] code);
    case (code)
      16'h0000, 16'h0013:            return CLS_LOAD;
      16'h0080, 16'h001A, 16'h001B:  return CLS_PROG;
      16'h0094, 16'h0095:            return CLS_ERASE;
      default:                       return CLS_NONE;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] doneMask(input opClass_e c);
    case (c)
      CLS_LOAD:  return bitOf(B_LDDN);
      CLS_PROG:  return bitOf(B_PRGDN);
      CLS_ERASE: return bitOf(B_ERADN);
      default:   return '0;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] errMask(input opClass_e c);
    case (c)
      CLS_LOAD:  return bitOf(B_ELD);
      CLS_PROG:  return bitOf(B_EPRG);
      CLS_ERASE: return bitOf(B_EERA);
      default:   return '0;
    endcase
  endfunction
endpackage

// File: rtl/fcc_ctrl.sv
module fcc_ctrl
  import fcc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmdWr,
  input  logic [DATA_W-1:0] cmdData,
  input  logic              masterPend,
  input  logic              engDone,
  input  logic              engFail,
  output ctlStrobe_t        strobe,
  output logic              engStart,
  output logic [DATA_W-1:0] engCmd
);
  logic     busy;
  opClass_e busyCls;
  opClass_e newCls;
  logic     accept;
  logic     launch;

  always_comb begin
    newCls = classOf(cmdData);
    accept = cmdWr && !masterPend && !busy;
    launch = accept && (newCls != CLS_NONE);
    strobe = '0;
    if (accept) begin
      strobe.cmdLoad = 1'b1;
      strobe.cmdCode = cmdData;
      if (newCls == CLS_NONE) begin
        case (cmdData)
          16'h0030: strobe.intSet = bitOf(B_MASTER) | bitOf(B_ERADN);
          16'h00B0: strobe.intSet = '0;
          16'h00F0, 16'h00F3: strobe.hotReset = 1'b1;
          16'h0023, 16'h0027, 16'h002A, 16'h002C, 16'h0065, 16'h0071:
            strobe.intSet = bitOf(B_MASTER);
          default: begin
            strobe.intSet = bitOf(B_MASTER);
            strobe.errSet = bitOf(B_ECMD);
          end
        endcase
      end
    end
    if (busy && engDone) begin
      strobe.intSet = bitOf(B_MASTER) | doneMask(busyCls);
      if (engFail) strobe.errSet = bitOf(B_ECMD) | errMask(busyCls);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      busyCls  <= CLS_NONE;
      engStart <= 1'b0;
      engCmd   <= '0;
    end else begin
      engStart <= launch;
      if (launch) begin
        busy    <= 1'b1;
        busyCls <= newCls;
        engCmd  <= cmdData;
      end else if (busy && engDone) begin
        busy    <= 1'b0;
        busyCls <= CLS_NONE;
      end
    end
  end

  // R5: launch strobe never lasts two cycles
  assert_start_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    engStart |=> !engStart);
  // R4: a blocked command leaves the engine side untouched
  assert_blocked_no_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdWr && masterPend) |=> (!engStart && $stable(engCmd)));
  // R5: while a command is outstanding, another write starts nothing
  assert_busy_no_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmdWr) |=> !engStart);
endmodule

// File: rtl/fcc_regs.sv
module fcc_regs
  import fcc_pkg::*;
#(
  parameter logic [DATA_W-1:0] CFG_RESET   = 16'h40C0,
  parameter logic [DATA_W-1:0] INT_COLD    = 16'h8080,
  parameter logic [DATA_W-1:0] INT_HOT     = 16'h8010,
  parameter logic [DATA_W-1:0] CFG_RD_MASK = 16'hFFE0,
  parameter int                POL_BIT     = 6,
  parameter int                RDY_BIT     = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctlStrobe_t        strobe,
  input  logic              cfgWr,
  input  logic              intWr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [SEL_W-1:0]  rdSel,
  output logic [DATA_W-1:0] rdData,
  output logic              masterPend,
  output logic              intPin,
  output logic              readyPin
);
  logic [DATA_W-1:0] cmdReg, cfgReg, statReg, intReg, intNext;

  always_comb begin
    intNext = (intWr ? (intReg & wrData) : intReg) | strobe.intSet;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmdReg   <= '0;
      cfgReg   <= CFG_RESET;
      statReg  <= '0;
      intReg   <= INT_COLD;
      readyPin <= 1'b1;
    end else if (strobe.hotReset) begin
      cmdReg   <= '0;
      cfgReg   <= CFG_RESET;
      statReg  <= '0;
      intReg   <= INT_HOT;
      readyPin <= 1'b1;
    end else begin
      if (strobe.cmdLoad) cmdReg <= strobe.cmdCode;
      if (cfgWr) begin
        cfgReg   <= wrData;
        readyPin <= wrData[RDY_BIT];
      end
      intReg  <= intNext;
      statReg <= intNext[B_MASTER] ? (statReg | (strobe.errSet & ERR_MASK))
                                   : (statReg & ~ERR_MASK);
    end
  end

  always_comb begin
    case (rdSel)
      SEL_CMD:  rdData = cmdReg;
      SEL_CFG:  rdData = cfgReg & CFG_RD_MASK;
      SEL_STAT: rdData = statReg;
      default:  rdData = intReg;
    endcase
  end

  assign masterPend = intReg[B_MASTER];
  assign intPin     = intReg[B_MASTER] ^ ~cfgReg[POL_BIT];

  // R3: no error flag survives a clear master bit
  assert_err_wiped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !intReg[B_MASTER] |-> ((statReg & ERR_MASK) == '0));
  // R6: bits posted by the control always land in the interrupt register
  assert_set_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((strobe.intSet != '0) && !strobe.hotReset) |=>
      ((intReg & $past(strobe.intSet)) == $past(strobe.intSet)));
  // R10: flipping the polarity bit alone flips the pin
  assert_pol_flip_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(cfgReg[POL_BIT]) && $stable(intReg[B_MASTER])) |-> !$stable(intPin));
  // R11: ready pin follows the written configuration bit
  assert_ready_follow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgWr && !strobe.hotReset) |=> (readyPin == $past(wrData[RDY_BIT])));
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import fcc_pkg::*;
#(
  parameter logic [15:0] CFG_RESET   = 16'h40C0,
  parameter logic [15:0] INT_COLD    = 16'h8080,
  parameter logic [15:0] INT_HOT     = 16'h8010,
  parameter logic [15:0] CFG_RD_MASK = 16'hFFE0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  busSel,
  input  logic        busWr,
  input  logic [15:0] busWrData,
  output logic [15:0] busRdData,
  output logic        engStart,
  output logic [15:0] engCmd,
  input  logic        engDone,
  input  logic        engFail,
  output logic        intPin,
  output logic        readyPin
);
  ctlStrobe_t strobe;
  logic       masterPend;
  logic       cmdWr, cfgWr, intWr;

  assign cmdWr = busWr && (busSel == SEL_CMD);
  assign cfgWr = busWr && (busSel == SEL_CFG);
  assign intWr = busWr && (busSel == SEL_INT);

  fcc_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmdWr      (cmdWr),
    .cmdData    (busWrData),
    .masterPend (masterPend),
    .engDone    (engDone),
    .engFail    (engFail),
    .strobe     (strobe),
    .engStart   (engStart),
    .engCmd     (engCmd)
  );

  fcc_regs #(
    .CFG_RESET   (CFG_RESET),
    .INT_COLD    (INT_COLD),
    .INT_HOT     (INT_HOT),
    .CFG_RD_MASK (CFG_RD_MASK)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .cfgWr      (cfgWr),
    .intWr      (intWr),
    .wrData     (busWrData),
    .rdSel      (busSel),
    .rdData     (busRdData),
    .masterPend (masterPend),
    .intPin     (intPin),
    .readyPin   (readyPin)
  );
endmodule

// File: tb/tb_flash_cmd_ctrl.sv
module tb_flash_cmd_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  busSel = 2'd0;
  logic        busWr = 1'b0;
  logic [15:0] busWrData = 16'h0;
  logic [15:0] busRdData;
  logic        engStart;
  logic [15:0] engCmd;
  logic        engDone = 1'b0;
  logic        engFail = 1'b0;
  logic        intPin;
  logic        readyPin;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;
  logic [15:0] expQ[$];

  always #2.5 clk = ~clk;

  flash_cmd_ctrl dut (
    .clk(clk), .rst_n(rst_n), .busSel(busSel), .busWr(busWr),
    .busWrData(busWrData), .busRdData(busRdData), .engStart(engStart),
    .engCmd(engCmd), .engDone(engDone), .engFail(engFail),
    .intPin(intPin), .readyPin(readyPin)
  );

  localparam logic [1:0] S_CMD = 2'd0, S_CFG = 2'd1, S_STAT = 2'd2, S_INT = 2'd3;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] sel, input logic [15:0] exp, input string tag);
    busSel = sel;
    #1;
    check(tag, busRdData, exp);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] data);
    busSel = sel; busWrData = data; busWr = 1'b1;
    @(posedge clk); #1;
    busWr = 1'b0;
  endtask

  // driver: queue the expected launch, then write the code
  task automatic launch(input logic [15:0] code);
    expQ.push_back(code);
    wr(S_CMD, code);
  endtask

  task automatic reply(input logic fail);
    engDone = 1'b1; engFail = fail;
    @(posedge clk); #1;
    engDone = 1'b0; engFail = 1'b0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  endtask

  // monitor: every launch strobe must match the queued code (R5)
  always @(negedge clk) begin
    if (rst_n && engStart) begin
      if (expQ.size() == 0) begin
        nChecks++; nFail++;
        $display("FAIL R5 unexpected start actual=%h expected=none", engCmd);
      end else begin
        check("R5 start code", engCmd, expQ.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    // R1 cold reset
    rd(S_CFG, 16'h40C0, "R1 cfg");
    rd(S_STAT, 16'h0000, "R1 stat");
    rd(S_INT, 16'h8080, "R1 int");
    rd(S_CMD, 16'h0000, "R1 cmd");
    check("R1 ready", {15'd0, readyPin}, 16'd1);
    check("R1 intPin", {15'd0, intPin}, 16'd1);
    // R4 blocked while master set
    wr(S_CMD, 16'h0000);
    @(posedge clk); #1;
    rd(S_CMD, 16'h0000, "R4 cmd kept");
    rd(S_INT, 16'h8080, "R4 int kept");
    // R2 AND-mask
    wr(S_INT, 16'hFF7F);
    rd(S_INT, 16'h8000, "R2 and mask");
    wr(S_INT, 16'h0000);
    rd(S_INT, 16'h0000, "R2 clear");
    check("R10 pin low", {15'd0, intPin}, 16'd0);
    // R5/R6 load success, busy blocking
    launch(16'h0013);
    rd(S_CMD, 16'h0013, "R5 cmd");
    wr(S_CMD, 16'h0080);
    @(posedge clk); #1;
    rd(S_CMD, 16'h0013, "R5 busy ignore");
    rd(S_INT, 16'h0000, "R5 no early bits");
    reply(1'b0);
    rd(S_INT, 16'h8080, "R6 load done");
    rd(S_STAT, 16'h0000, "R6 load ok stat");
    check("R10 pin high", {15'd0, intPin}, 16'd1);
    wr(S_INT, 16'h0000);
    // R6 program fail, R3 keep/wipe
    launch(16'h001B);
    reply(1'b1);
    rd(S_INT, 16'h8040, "R6 prog done");
    rd(S_STAT, 16'h1400, "R6 prog err");
    wr(S_INT, 16'h8000);
    rd(S_STAT, 16'h1400, "R3 kept");
    wr(S_INT, 16'h0000);
    rd(S_STAT, 16'h0000, "R3 wiped");
    // R6 erase fail and load fail
    launch(16'h0095);
    reply(1'b1);
    rd(S_INT, 16'h8020, "R6 erase done");
    rd(S_STAT, 16'h0C00, "R6 erase err");
    wr(S_INT, 16'h0000);
    launch(16'h0000);
    reply(1'b1);
    rd(S_STAT, 16'h2400, "R6 load err");
    wr(S_INT, 16'h0000);
    // R5 done while idle ignored
    reply(1'b1);
    rd(S_INT, 16'h0000, "R5 idle done int");
    rd(S_STAT, 16'h0000, "R5 idle done stat");
    // R7 immediate codes
    wr(S_CMD, 16'h0030);
    rd(S_INT, 16'h8020, "R7 resume");
    wr(S_INT, 16'h0000);
    wr(S_CMD, 16'h00B0);
    rd(S_INT, 16'h0000, "R7 suspend int");
    rd(S_CMD, 16'h00B0, "R7 suspend cmd");
    wr(S_CMD, 16'h002A);
    rd(S_INT, 16'h8000, "R7 array code");
    rd(S_STAT, 16'h0000, "R7 array stat");
    wr(S_INT, 16'h0000);
    // R8 unknown code
    wr(S_CMD, 16'h0155);
    rd(S_INT, 16'h8000, "R8 int");
    rd(S_STAT, 16'h0400, "R8 stat");
    wr(S_INT, 16'h0000);
    rd(S_STAT, 16'h0000, "R3 wipe cmd err");
    // R11 config, R10 polarity
    wr(S_CFG, 16'h405F);
    rd(S_CFG, 16'h4040, "R11 mask");
    check("R11 ready low", {15'd0, readyPin}, 16'd0);
    wr(S_CFG, 16'h0000);
    check("R10 inverted pol", {15'd0, intPin}, 16'd1);
    wr(S_CFG, 16'h00FF);
    rd(S_CFG, 16'h00E0, "R11 mask2");
    check("R11 ready high", {15'd0, readyPin}, 16'd1);
    check("R10 pol normal", {15'd0, intPin}, 16'd0);
    // R9 hot resets
    wr(S_CFG, 16'h0000);
    wr(S_CMD, 16'h00F0);
    rd(S_CFG, 16'h40C0, "R9 cfg");
    rd(S_INT, 16'h8010, "R9 int");
    rd(S_CMD, 16'h0000, "R9 cmd");
    check("R9 ready", {15'd0, readyPin}, 16'd1);
    wr(S_INT, 16'h0000);
    wr(S_CFG, 16'h0000);
    wr(S_CMD, 16'h00F3);
    rd(S_INT, 16'h8010, "R9 int F3");
    rd(S_CFG, 16'h40C0, "R9 cfg F3");
    rd(S_STAT, 16'h0000, "R9 stat");
    wr(S_INT, 16'h0000);
    // R12 collisions: completion and interrupt write on one edge
    launch(16'h0080);
    engDone = 1'b1; engFail = 1'b1;
    wr(S_INT, 16'h0000);
    engDone = 1'b0; engFail = 1'b0;
    rd(S_INT, 16'h8040, "R12 fail int");
    rd(S_STAT, 16'h1400, "R12 fail stat");
    wr(S_INT, 16'h0000);
    launch(16'h0094);
    engDone = 1'b1;
    wr(S_INT, 16'h0000);
    engDone = 1'b0;
    rd(S_INT, 16'h8020, "R12 ok int");
    rd(S_STAT, 16'h0000, "R12 ok stat");
    // R13 status is read-only
    wr(S_STAT, 16'hFFFF);
    rd(S_STAT, 16'h0000, "R13 stat ro");
    repeat (2) @(posedge clk); #1;
    check("R5 queue drained", 16'(expQ.size()), 16'd0);
    finish();
  end
endmodule